// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that gives an external bus master byte-wide read and write access to a register file inside the chip. SCL and SDA are sampled in the system clock domain after a two-stage synchronizer. The block detects START, repeated START and STOP, and matches a 7-bit device select code that is set by a parameter. It acknowledges bytes, and it returns read data by pulling SDA low through an open-drain enable.

A single 8-bit address pointer is kept from one transfer to the next. A write transfer loads the pointer from its first byte and stores each following byte at the pointer, advancing the pointer after each one. A read can start in two ways:

- A current-address read begins directly at the pointer.
- A random-address read first sends a sub-address in a write phase, then a repeated START switches to reading from that sub-address.

Every byte transferred in either direction advances the pointer.

The register-file side has no handshake and no back-pressure. The block emits a one-cycle write strobe carrying the address and data. It reads through a combinational path: the block presents the pointer on `reg_rd_addr`, and the register file must return `reg_rd_data` in the same cycle. The system clock must run at least ten times faster than SCL.

Top module: `i2c_rf_target`

## Requirements
- R1: After reset, `sda_oe` is 0, `reg_wr_en` is 0 and the pointer presented on `reg_rd_addr` is 0x00.
- R2: Bytes are sent MSB first. Bits 7:1 of the first byte after a START are the select code and bit 0 is the direction (0 = write, 1 = read). A select code equal to `DEV_ADDR` is acknowledged by driving `sda_oe` high for the ninth clock. Any other select code gets no acknowledgement, and all bus activity is ignored until the next START.
- R3: In a write transfer the byte after the select byte is acknowledged and loaded into the pointer.
- R4: Each further write byte is acknowledged. It produces exactly one single-cycle `reg_wr_en` pulse, with `reg_wr_addr` set to the pointer and `reg_wr_data` set to the byte. The pointer then advances by one.
- R5: The pointer wraps from 0xFF to 0x00, for writes and for reads.
- R6: A select byte with direction 1 that directly follows a START returns data starting at the current pointer.
- R7: A sub-address written in a write phase, followed by a repeated START and a read select, returns data starting at that sub-address.
- R8: Read bytes are driven MSB first, with `sda_oe` = 1 for a 0 bit and `sda_oe` = 0 for a 1 bit. While the master acknowledges, consecutive bytes come from consecutive addresses.
- R9: After a master NACK the block releases SDA (`sda_oe` = 0), drives no further data and goes idle. The pointer has already moved past the last byte read.
- R10: A STOP or a START in the middle of a byte abandons that byte. An abandoned write byte produces no write strobe, and after a repeated START the next byte is taken as a select byte.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 8 | Register write address |
| reg_wr_data | output | 8 | Register write data |
| reg_rd_addr | output | 8 | Current pointer, used as the register read address |
| reg_rd_data | input | 8 | Register read data, combinational from `reg_rd_addr` |

## Verification
Every result of this block appears 3 system cycles after the SCL edge that causes it: two synchronizer stages plus one state register. This applies to an acknowledgement or data bit on `sda_oe`, a write strobe, and a pointer update. The bench master changes SDA a quarter SCL period (5 cycles) after each falling edge of SCL, and samples the line a quarter period after each rising edge. Every sample therefore falls well after the due cycle and well before the next edge. Write strobes are counted at every clock edge. The pointer and the register contents are checked only once a STOP or NACK has ended the transfer.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  // Idle bus level is high; reset to that so no false edge appears.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
      prev_q <= 1'b1;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], raw_i};
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~prev_q;
  assign fall_o = ~pipe_q[STAGES-1] & prev_q;
endmodule

// File: rtl/i2c_rf_ptr.sv
module i2c_rf_ptr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ptr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ADDR_W'(ptr_o + 1'b1);  // natural wrap
  end
endmodule

// File: rtl/i2c_rf_target.sv
module i2c_rf_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         ADDR_W      = 8,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic [ADDR_W-1:0] reg_rd_addr,
  input  logic [DATA_W-1:0] reg_rd_data
);
  import i2c_rf_pkg::*;

  localparam int                CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(DATA_W - 1);

  // Line conditioning: index 0 = SCL, index 1 = SDA
  logic [1:0] raw_w, lvl_w, rise_w, fall_w;
  assign raw_w = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_rf_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_w[g]),
      .lvl_o  (lvl_w[g]),
      .rise_o (rise_w[g]),
      .fall_o (fall_w[g])
    );
  end

  logic scl, sda, scl_rise, scl_fall, start_c, stop_c;
  assign scl      = lvl_w[0];
  assign sda      = lvl_w[1];
  assign scl_rise = rise_w[0];
  assign scl_fall = fall_w[0];
  assign start_c  = fall_w[1] & scl & ~scl_rise;
  assign stop_c   = rise_w[1] & scl & ~scl_rise;

  tgt_state_e        state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [DATA_W-1:0] rx_sr_q, tx_sr_q;
  logic              byte_done_q, rw_q, mack_q, sda_oe_q;
  logic              wr_en_q;
  logic [ADDR_W-1:0] wr_addr_q, ptr_w;
  logic [DATA_W-1:0] wr_data_q;

  // Pointer control, decoded from the same events the FSM acts on
  logic ptr_load, ptr_inc, bus_evt;
  assign bus_evt  = start_c | stop_c;
  assign ptr_load = !bus_evt && scl_fall && byte_done_q && (state_q == ST_SUB);
  assign ptr_inc  = !bus_evt && scl_fall &&
                    (((state_q == ST_WR) && byte_done_q) ||
                     ((state_q == ST_RD) && (bit_cnt_q == LAST)));

  i2c_rf_ptr #(.ADDR_W(ADDR_W)) ptr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ptr_load),
    .load_val_i (ADDR_W'(rx_sr_q)),
    .inc_i      (ptr_inc),
    .ptr_o      (ptr_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      rx_sr_q     <= '0;
      tx_sr_q     <= '0;
      byte_done_q <= 1'b0;
      rw_q        <= 1'b0;
      mack_q      <= 1'b0;
      sda_oe_q    <= 1'b0;
      wr_en_q     <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_c) begin
        state_q     <= ST_DEV;
        bit_cnt_q   <= '0;
        byte_done_q <= 1'b0;
        sda_oe_q    <= 1'b0;
      end else if (stop_c) begin
        state_q     <= ST_IDLE;
        byte_done_q <= 1'b0;
        sda_oe_q    <= 1'b0;
      end else begin
        case (state_q)
          ST_DEV, ST_SUB, ST_WR: begin
            if (scl_rise) begin
              rx_sr_q   <= {rx_sr_q[DATA_W-2:0], sda};
              bit_cnt_q <= CNT_W'(bit_cnt_q + 1'b1);
              if (bit_cnt_q == LAST) byte_done_q <= 1'b1;
            end else if (scl_fall && byte_done_q) begin
              byte_done_q <= 1'b0;
              case (state_q)
                ST_DEV: begin
                  if (rx_sr_q[DATA_W-1:1] == DEV_ADDR) begin
                    sda_oe_q <= 1'b1;
                    rw_q     <= rx_sr_q[0];
                    state_q  <= ST_DEV_ACK;
                  end else begin
                    state_q  <= ST_IDLE;
                  end
                end
                ST_SUB: begin
                  sda_oe_q <= 1'b1;
                  state_q  <= ST_SUB_ACK;
                end
                default: begin
                  sda_oe_q  <= 1'b1;
                  wr_en_q   <= 1'b1;
                  wr_addr_q <= ptr_w;
                  wr_data_q <= rx_sr_q;
                  state_q   <= ST_WR_ACK;
                end
              endcase
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              bit_cnt_q <= '0;
              if (rw_q) begin
                tx_sr_q  <= reg_rd_data;
                sda_oe_q <= ~reg_rd_data[DATA_W-1];
                state_q  <= ST_RD;
              end else begin
                sda_oe_q <= 1'b0;
                state_q  <= ST_SUB;
              end
            end
          end
          ST_SUB_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe_q  <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bit_cnt_q == LAST) begin
                sda_oe_q <= 1'b0;
                state_q  <= ST_RD_ACK;
              end else begin
                tx_sr_q   <= {tx_sr_q[DATA_W-2:0], 1'b0};
                sda_oe_q  <= ~tx_sr_q[DATA_W-2];
                bit_cnt_q <= CNT_W'(bit_cnt_q + 1'b1);
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda;
            end else if (scl_fall) begin
              if (mack_q) begin
                tx_sr_q   <= reg_rd_data;
                sda_oe_q  <= ~reg_rd_data[DATA_W-1];
                bit_cnt_q <= '0;
                state_q   <= ST_RD;
              end else begin
                sda_oe_q  <= 1'b0;
                state_q   <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe      = sda_oe_q;
  assign reg_wr_en   = wr_en_q;
  assign reg_wr_addr = wr_addr_q;
  assign reg_wr_data = wr_data_q;
  assign reg_rd_addr = ptr_w;

  // R11: the open-drain enable only moves while the bus clock is low
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_q != $past(sda_oe_q)) |-> !$past(scl));

  // R4: a write strobe lasts one cycle
  p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |=> !wr_en_q);

  // R4/R5: the pointer sits one past the address being written
  p_wr_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> (ptr_w == ADDR_W'(wr_addr_q + 1'b1)));

  // R9: an idle target never holds SDA low
  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_oe_q);
endmodule

// File: tb/i2c_rf_target_tb_top.sv
module i2c_rf_target_tb_top;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_wr_en, sda_line;
  logic [7:0] reg_wr_addr, reg_wr_data, reg_rd_addr, reg_rd_data;

  logic [7:0] regs    [256];
  logic [7:0] exp_mem [256];
  int checks = 0, fails = 0, wr_count = 0, viol = 0;
  logic prev_oe = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign sda_line    = sda_m & ~sda_oe;
  assign reg_rd_data = regs[reg_rd_addr];

  i2c_rf_target #(.DEV_ADDR(DEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr),
    .reg_rd_data(reg_rd_data));

  always @(posedge clk) if (reg_wr_en) begin
    regs[reg_wr_addr] <= reg_wr_data;
    wr_count <= wr_count + 1;
  end

  // R11 monitor
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && scl_m) viol++;
    prev_oe = sda_oe;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic q_wait(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b0; q_wait(); scl_m = 1'b0; q_wait();
  endtask
  task automatic bus_rstart();
    sda_m = 1'b1; q_wait(); scl_m = 1'b1; q_wait();
    sda_m = 1'b0; q_wait(); scl_m = 1'b0; q_wait();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; q_wait(); scl_m = 1'b1; q_wait(); sda_m = 1'b1; q_wait();
  endtask
  task automatic put_bit(logic b);
    sda_m = b; q_wait(); scl_m = 1'b1; q_wait(); q_wait(); scl_m = 1'b0; q_wait();
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1'b1; q_wait(); scl_m = 1'b1; q_wait(); b = sda_line;
    q_wait(); scl_m = 1'b0; q_wait();
  endtask
  task automatic put_byte(logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask
  task automatic get_byte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(~mack);
  endtask

  task automatic write_seq(logic [7:0] sub, int n, logic [7:0] base);
    logic ack;
    bus_start();
    put_byte({DEV, 1'b0}, ack); chk("R2 select ack", ack, 1);
    put_byte(sub, ack);         chk("R3 sub ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      put_byte(8'(base + i), ack); chk("R4 data ack", ack, 1);
      exp_mem[8'(sub + i)] = 8'(base + i);
    end
    bus_stop();
  endtask

  // random read when rnd=1, current-address read otherwise
  task automatic read_seq(bit rnd, logic [7:0] sub, int n, string tag);
    logic ack;
    logic [7:0] d, a;
    bus_start();
    if (rnd) begin
      put_byte({DEV, 1'b0}, ack); chk("R2 select ack", ack, 1);
      put_byte(sub, ack);         chk("R3 sub ack", ack, 1);
      bus_rstart();
      a = sub;
    end else begin
      a = reg_rd_addr;
    end
    put_byte({DEV, 1'b1}, ack); chk("R2 read select ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(d, i != n - 1);
      chk(tag, d, exp_mem[8'(a + i)]);
    end
    chk("R9 released after NACK", sda_oe, 0);
    bus_stop();
    chk("R9 pointer past last read", reg_rd_addr, 8'(a + n));
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) begin
      regs[i] = 8'(i * 3 + 1);
      exp_mem[i] = 8'(i * 3 + 1);
    end
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sda_oe reset", sda_oe, 0);
    chk("R1 wr_en reset", reg_wr_en, 0);
    chk("R1 pointer reset", reg_rd_addr, 0);

    // R2: sweep every select code
    for (int a = 0; a < 128; a++) begin
      bus_start();
      put_byte({7'(a), 1'b0}, ack);
      chk("R2 select match sweep", ack, (7'(a) == DEV));
      bus_stop();
    end
    // R2: after a mismatch, even the right code is ignored until START
    bus_start();
    put_byte({7'h15, 1'b0}, ack); chk("R2 mismatch nack", ack, 0);
    put_byte({DEV, 1'b0}, ack);   chk("R2 ignored until START", ack, 0);
    bus_stop();
    chk("R2 no writes during sweep", wr_count, 0);

    // R3/R4: multi-byte write
    write_seq(8'h10, 3, 8'hA0);
    chk("R4 strobe count", wr_count, 3);
    chk("R4 pointer after write", reg_rd_addr, 8'h13);
    for (int i = 0; i < 3; i++) chk("R4 stored data", regs[8'h10 + i], 8'hA0 + i);

    // R5: wrap on write
    write_seq(8'hFE, 3, 8'hC0);
    chk("R5 wrap FE", regs[8'hFE], 8'hC0);
    chk("R5 wrap FF", regs[8'hFF], 8'hC1);
    chk("R5 wrap 00", regs[8'h00], 8'hC2);
    chk("R5 pointer wrapped", reg_rd_addr, 8'h01);

    read_seq(1'b1, 8'h10, 3, "R7 random read data");
    read_seq(1'b0, 8'h00, 1, "R6 current read data");
    // R8: sequential sweeps, including across the wrap (R5)
    read_seq(1'b1, 8'h00, 12, "R8 sequential read");
    read_seq(1'b1, 8'h7F, 12, "R8 sequential read");
    read_seq(1'b1, 8'hF8, 12, "R5 R8 read across wrap");
    read_seq(1'b0, 8'h00, 5, "R6 R8 current sequential");

    // R10: STOP in the middle of a data byte
    wr_count = 0;
    bus_start();
    put_byte({DEV, 1'b0}, ack);
    put_byte(8'h40, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    chk("R10 no write after STOP abort", wr_count, 0);
    chk("R10 pointer holds sub-address", reg_rd_addr, 8'h40);
    read_seq(1'b0, 8'h00, 1, "R10 data unchanged after abort");

    // R10: repeated START in the middle of a data byte
    bus_start();
    put_byte({DEV, 1'b0}, ack);
    put_byte(8'h50, ack);
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    bus_rstart();
    put_byte({DEV, 1'b1}, ack); chk("R10 select after rSTART", ack, 1);
    get_byte(d, 1'b0);
    chk("R10 read after rSTART abort", d, exp_mem[8'h50]);
    bus_stop();
    chk("R10 no write after rSTART abort", wr_count, 0);

    chk("R11 sda_oe changed while SCL high", viol, 0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule